// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for one single-register load or store and, where the addressing mode asks for it, the updated base-register value. A request carries a base value, a signed 12-bit immediate with an add/subtract flag, a mode code, a load/store flag, a byte/word flag, a flag saying whether the load destination is the base register itself, the instruction address used for PC-relative forms, and the store data. One clock later the block presents a memory request, a base write-back and, for loads, the formatted load data. All three appear together as single-cycle pulses.

The memory is byte-addressed and little-endian. Byte lane n carries bits 8n+7:8n of the data word, and it is selected when address bits [1:0] equal n. The memory answers reads combinationally in the request cycle. The block selects the addressed lane for byte loads and zero-extends it. For byte stores it copies the low source byte onto every lane, so that the single byte enable picks the right one. A word access whose address is not a multiple of 4 is refused with an alignment-fault pulse. Decoding, the register file and the memory itself lie outside the block.

Top module: `lsagu_top`

## Requirements
- R1: Mode code 0 (indirect) addresses memory at the base value and requests no write-back. The unused codes 5, 6 and 7 behave the same way.
- R2: Mode code 1 (pre-indexed) addresses memory at base plus the signed offset and requests no write-back.
- R3: Mode code 2 (pre-indexed with write-back) addresses memory at base plus offset and writes that same sum back as the new base.
- R4: Mode code 3 (post-indexed) addresses memory at the unmodified base and writes base plus offset back as the new base.
- R5: The 12-bit offset is sign-extended to 32 bits. It is added when the up flag is 1 and subtracted when the up flag is 0.
- R6: Mode code 4 (PC-relative) addresses memory at the instruction address plus 8, with the signed offset added or subtracted per the up flag. It requests no write-back.
- R7: A word access drives byte enables 4'b1111 and the store data unchanged, and a word load returns all 32 bits. A word access whose address bits [1:0] are not 0 raises the alignment fault and issues neither a memory request nor a write-back, so memory is left unchanged.
- R8: A byte access drives the single byte enable bit numbered by address bits [1:0] and copies the low source byte onto all four lanes. A byte load returns that lane zero-extended to 32 bits.
- R9: The memory request, the write-back and the load data appear exactly one clock after the accepted request, each as a one-cycle pulse. The load result is valid only alongside a read request.
- R10: When a load's destination is the base register, the write-back is suppressed and the loaded value is the only result.
- R11: While reset is held, the memory request, write-back, load-valid and fault outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_mode | input | 3 | Addressing mode code (0 indirect, 1 pre, 2 pre with write-back, 3 post, 4 PC-relative) |
| req_up | input | 1 | 1 adds the offset, 0 subtracts it |
| req_store | input | 1 | 1 store, 0 load |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_dest_is_base | input | 1 | Load destination is the base register |
| req_base | input | 32 | Base register value |
| req_pc | input | 32 | Address of the current instruction |
| req_offset | input | 12 | Signed immediate offset |
| req_sdata | input | 32 | Store source data |
| mem_valid | output | 1 | Memory request pulse |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_be | output | 4 | Byte enables, bit n for lane n |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for mem_addr, same cycle |
| ld_valid | output | 1 | Load result pulse |
| ld_data | output | 32 | Load result, zero-extended for bytes |
| wb_valid | output | 1 | Base write-back pulse |
| wb_base | output | 32 | New base value |
| align_fault | output | 1 | Misaligned word access pulse |

## Verification
The bench checks every indexing mode against addresses and write-back values worked out from the mode rules. A design that swapped pre- and post-indexing would show the wrong address in one case and the wrong new base in the other. Negative offsets and subtraction through the up flag are both exercised, which exposes a zero-extended offset or an ignored direction flag. Byte accesses at odd lanes check the lane numbering and the zero-extension, and a lane choice from the wrong end would return the wrong byte. Misaligned word stores are followed by a read-back that proves memory was untouched. A load into its own base register checks that the write-back gives way to the load.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

   typedef enum logic [2:0] {
      AM_INDIRECT = 3'd0,
      AM_PRE      = 3'd1,
      AM_PRE_WB   = 3'd2,
      AM_POST     = 3'd3,
      AM_PCREL    = 3'd4
   } addr_mode_e;

endpackage

// File: rtl/lsagu_addr_calc.sv
module lsagu_addr_calc
   import lsagu_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 12,
   parameter int PC_BIAS   = 8,
   parameter bit HAS_PCREL = 1'b1
) (
   input  logic [2:0]        mode,
   input  logic              up,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] new_base,
   output logic              wb_req
);

   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] delta;
   logic [ADDR_W-1:0] indexed;
   logic [ADDR_W-1:0] pc_addr;
   logic              pcrel_sel;

   assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
   assign delta   = up ? off_ext : (~off_ext + 1'b1);
   assign indexed = base + delta;

   generate
      if (HAS_PCREL) begin : g_pcrel
         assign pc_addr   = pc + ADDR_W'(PC_BIAS) + delta;
         assign pcrel_sel = (mode == AM_PCREL);
      end else begin : g_no_pcrel
         assign pc_addr   = base;
         assign pcrel_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      eff_addr = base;
      new_base = indexed;
      wb_req   = 1'b0;
      case (addr_mode_e'(mode))
         AM_PRE:    eff_addr = indexed;
         AM_PRE_WB: begin
            eff_addr = indexed;
            wb_req   = 1'b1;
         end
         AM_POST:   wb_req = 1'b1;
         default:   eff_addr = pcrel_sel ? pc_addr : base;
      endcase
   end

endmodule

// File: rtl/lsagu_lanes.sv
module lsagu_lanes #(
   parameter int DATA_W = 32,
   localparam int LANES     = DATA_W / 8,
   localparam int LANE_BITS = $clog2(LANES)
) (
   input  logic                 is_byte,
   input  logic [LANE_BITS-1:0] lane,
   input  logic [DATA_W-1:0]    sdata,
   output logic [LANES-1:0]     be,
   output logic [DATA_W-1:0]    wdata,
   output logic                 misaligned
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_be
         assign be[g] = is_byte ? (lane == LANE_BITS'(g)) : 1'b1;
      end
   endgenerate

   assign wdata      = is_byte ? {LANES{sdata[7:0]}} : sdata;
   assign misaligned = !is_byte && (lane != '0);

endmodule

// File: rtl/lsagu_load_fmt.sv
module lsagu_load_fmt #(
   parameter int DATA_W = 32,
   localparam int LANES     = DATA_W / 8,
   localparam int LANE_BITS = $clog2(LANES)
) (
   input  logic                 is_byte,
   input  logic [LANE_BITS-1:0] lane,
   input  logic [DATA_W-1:0]    rdata,
   output logic [DATA_W-1:0]    ld_data
);

   logic [7:0] lane_byte [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_byte[g] = rdata[8*g +: 8];
      end
   endgenerate

   assign ld_data = is_byte ? {{(DATA_W-8){1'b0}}, lane_byte[lane]} : rdata;

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int OFF_W     = 12,
   parameter int PC_BIAS   = 8,
   parameter bit HAS_PCREL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [2:0]            req_mode,
   input  logic                  req_up,
   input  logic                  req_store,
   input  logic                  req_byte,
   input  logic                  req_dest_is_base,
   input  logic [ADDR_W-1:0]     req_base,
   input  logic [ADDR_W-1:0]     req_pc,
   input  logic [OFF_W-1:0]      req_offset,
   input  logic [DATA_W-1:0]     req_sdata,
   output logic                  mem_valid,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W/8-1:0]   mem_be,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  ld_valid,
   output logic [DATA_W-1:0]     ld_data,
   output logic                  wb_valid,
   output logic [ADDR_W-1:0]     wb_base,
   output logic                  align_fault
);

   localparam int LANES     = DATA_W / 8;
   localparam int LANE_BITS = $clog2(LANES);

   generate
      if (DATA_W % 8 != 0 || LANES < 2 || (1 << LANE_BITS) != LANES) begin : g_bad_data
         $error("lsagu_top: DATA_W must be a power-of-two number of bytes, at least 2");
      end
      if (OFF_W < 2 || OFF_W >= ADDR_W) begin : g_bad_off
         $error("lsagu_top: OFF_W must be below ADDR_W");
      end
      if (ADDR_W <= LANE_BITS) begin : g_bad_addr
         $error("lsagu_top: ADDR_W too narrow");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] new_base;
   logic              wb_req;
   logic [LANES-1:0]  be_c;
   logic [DATA_W-1:0] wdata_c;
   logic              misaligned;
   logic              wb_take;

   lsagu_addr_calc #(
      .ADDR_W    (ADDR_W),
      .OFF_W     (OFF_W),
      .PC_BIAS   (PC_BIAS),
      .HAS_PCREL (HAS_PCREL)
   ) u_calc (
      .mode     (req_mode),
      .up       (req_up),
      .base     (req_base),
      .pc       (req_pc),
      .offset   (req_offset),
      .eff_addr (eff_addr),
      .new_base (new_base),
      .wb_req   (wb_req)
   );

   lsagu_lanes #(.DATA_W(DATA_W)) u_lanes (
      .is_byte    (req_byte),
      .lane       (eff_addr[LANE_BITS-1:0]),
      .sdata      (req_sdata),
      .be         (be_c),
      .wdata      (wdata_c),
      .misaligned (misaligned)
   );

   // a load into the base register wins over the write-back
   assign wb_take = wb_req && !misaligned && (req_store || !req_dest_is_base);

   logic                 r_valid, r_we, r_byte, r_wb, r_fault;
   logic [ADDR_W-1:0]    r_addr, r_wb_base;
   logic [LANES-1:0]     r_be;
   logic [DATA_W-1:0]    r_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_valid   <= 1'b0;
         r_fault   <= 1'b0;
         r_wb      <= 1'b0;
         r_we      <= 1'b0;
         r_byte    <= 1'b0;
         r_addr    <= '0;
         r_wb_base <= '0;
         r_be      <= '0;
         r_wdata   <= '0;
      end else begin
         r_valid <= req_valid && !misaligned;
         r_fault <= req_valid && misaligned;
         r_wb    <= req_valid && wb_take;
         if (req_valid) begin
            r_we      <= req_store;
            r_byte    <= req_byte;
            r_addr    <= eff_addr;
            r_wb_base <= new_base;
            r_be      <= be_c;
            r_wdata   <= wdata_c;
         end
      end
   end

   lsagu_load_fmt #(.DATA_W(DATA_W)) u_fmt (
      .is_byte (r_byte),
      .lane    (r_addr[LANE_BITS-1:0]),
      .rdata   (mem_rdata),
      .ld_data (ld_data)
   );

   assign mem_valid   = r_valid;
   assign mem_we      = r_we;
   assign mem_addr    = r_addr;
   assign mem_be      = r_be;
   assign mem_wdata   = r_wdata;
   assign ld_valid    = r_valid && !r_we;
   assign wb_valid    = r_wb;
   assign wb_base     = r_wb_base;
   assign align_fault = r_fault;

endmodule

// File: rtl/lsagu_checker.sv
module lsagu_checker #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int OFF_W     = 12,
   parameter int PC_BIAS   = 8,
   parameter bit HAS_PCREL = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [2:0]          req_mode,
   input logic                req_up,
   input logic                req_store,
   input logic                req_byte,
   input logic                req_dest_is_base,
   input logic [ADDR_W-1:0]   req_base,
   input logic [ADDR_W-1:0]   req_pc,
   input logic [OFF_W-1:0]    req_offset,
   input logic                mem_valid,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic                ld_valid,
   input logic                wb_valid,
   input logic [ADDR_W-1:0]   wb_base,
   input logic                align_fault
);

   logic [ADDR_W-1:0] c_off;
   logic [ADDR_W-1:0] c_step;
   logic              c_base_kept;

   assign c_off       = ADDR_W'($signed(req_offset));
   assign c_step      = req_up ? c_off : (ADDR_W'(0) - c_off);
   assign c_base_kept = !req_store && req_dest_is_base;

   p_indirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_mode == 3'd0 || req_mode > 3'd4) |=>
         align_fault || (mem_addr == $past(req_base) && !wb_valid));

   p_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == 3'd1 |=>
         align_fault || (mem_addr == $past(req_base + c_step) && !wb_valid));

   p_pre_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == 3'd2 && !c_base_kept |=>
         align_fault || (mem_addr == $past(req_base + c_step) && wb_valid
                         && wb_base == $past(req_base + c_step)));

   p_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == 3'd3 && !c_base_kept |=>
         align_fault || (mem_addr == $past(req_base) && wb_valid
                         && wb_base == $past(req_base + c_step)));

   p_pcrel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && HAS_PCREL && req_mode == 3'd4 |=>
         align_fault || (mem_addr == $past(req_pc + ADDR_W'(PC_BIAS) + c_step) && !wb_valid));

   p_word_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_byte |=> align_fault || (mem_valid && (&mem_be)));

   p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !mem_valid && !wb_valid && !ld_valid);

   p_byte_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_byte |=> mem_valid && $countones(mem_be) == 1);

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !mem_valid && !wb_valid && !align_fault);

   p_ld_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> mem_valid && !mem_we);

   p_ld_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && c_base_kept |=> !wb_valid);

endmodule

bind lsagu_top lsagu_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .OFF_W     (OFF_W),
   .PC_BIAS   (PC_BIAS),
   .HAS_PCREL (HAS_PCREL)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_mode         (req_mode),
   .req_up           (req_up),
   .req_store        (req_store),
   .req_byte         (req_byte),
   .req_dest_is_base (req_dest_is_base),
   .req_base         (req_base),
   .req_pc           (req_pc),
   .req_offset       (req_offset),
   .mem_valid        (mem_valid),
   .mem_we           (mem_we),
   .mem_addr         (mem_addr),
   .mem_be           (mem_be),
   .ld_valid         (ld_valid),
   .wb_valid         (wb_valid),
   .wb_base          (wb_base),
   .align_fault      (align_fault)
);

// File: tb/lsagu_top_test.sv
`timescale 1ns/1ps
module lsagu_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic        req_up = 1'b1;
   logic        req_store = 1'b0;
   logic        req_byte = 1'b0;
   logic        req_dest_is_base = 1'b0;
   logic [31:0] req_base = '0;
   logic [31:0] req_pc = '0;
   logic [11:0] req_offset = '0;
   logic [31:0] req_sdata = '0;
   logic        mem_valid, mem_we, ld_valid, wb_valid, align_fault;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data, wb_base;
   logic [3:0]  mem_be;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lsagu_top uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_up(req_up), .req_store(req_store), .req_byte(req_byte),
      .req_dest_is_base(req_dest_is_base), .req_base(req_base), .req_pc(req_pc),
      .req_offset(req_offset), .req_sdata(req_sdata), .mem_valid(mem_valid),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
      .wb_valid(wb_valid), .wb_base(wb_base), .align_fault(align_fault)
   );

   // bench memory: 256 words, combinational read, byte-enabled write
   logic [31:0] mem [256];
   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else if (mem_valid && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
   end

   logic [31:0] model [256];

   typedef struct {
      logic        fault;
      logic [31:0] addr;
      logic        we;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        wbv;
      logic [31:0] wbd;
      logic        ldv;
      logic [31:0] ldd;
   } exp_t;

   exp_t  q[$];
   string qtag[$];

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: compute the expected result, queue it, present the request
   task automatic issue(input string tag, input logic [2:0] mode, input logic up,
                        input logic st, input logic byt, input logic dib,
                        input logic [31:0] base, input logic [31:0] pc,
                        input logic [11:0] off, input logic [31:0] sd);
      exp_t        e;
      logic [31:0] offx, d, idx, ea, word;
      offx = {{20{off[11]}}, off};
      d    = up ? offx : -offx;
      idx  = base + d;
      e.wbv = 1'b0;
      e.wbd = idx;
      case (mode)
         3'd1: ea = idx;
         3'd2: begin ea = idx; e.wbv = 1'b1; end
         3'd3: begin ea = base; e.wbv = 1'b1; end
         3'd4: ea = pc + 32'd8 + d;
         default: ea = base;
      endcase
      e.fault = !byt && (ea[1:0] != 2'b00);
      if (e.fault || (!st && dib)) e.wbv = 1'b0;
      e.addr  = ea;
      e.we    = st;
      e.be    = byt ? (4'b0001 << ea[1:0]) : 4'b1111;
      e.wdata = byt ? {4{sd[7:0]}} : sd;
      e.ldv   = !st && !e.fault;
      word    = model[ea[9:2]];
      e.ldd   = byt ? ((word >> (8 * ea[1:0])) & 32'hFF) : word;
      if (st && !e.fault)
         for (int b = 0; b < 4; b++)
            if (e.be[b]) model[ea[9:2]][8*b +: 8] = e.wdata[8*b +: 8];
      @(negedge clk);
      q.push_back(e);
      qtag.push_back(tag);
      req_valid = 1'b1; req_mode = mode; req_up = up; req_store = st;
      req_byte = byt; req_dest_is_base = dib; req_base = base; req_pc = pc;
      req_offset = off; req_sdata = sd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: pop one expected item per observed transfer or fault
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_valid || align_fault) begin
            if (q.size() == 0) begin
               chk("R9", "unexpected transfer", 32'd1, 32'd0);
            end else begin
               exp_t  e;
               string t;
               e = q.pop_front();
               t = qtag.pop_front();
               chk(t, "align_fault", 32'(align_fault), 32'(e.fault));
               if (e.fault) begin
                  chk(t, "mem_valid on fault", 32'(mem_valid), 32'd0);
                  chk(t, "wb_valid on fault", 32'(wb_valid), 32'd0);
               end else begin
                  chk(t, "mem_addr", mem_addr, e.addr);
                  chk(t, "mem_we", 32'(mem_we), 32'(e.we));
                  chk(t, "mem_be", 32'(mem_be), 32'(e.be));
                  if (e.we) chk(t, "mem_wdata", mem_wdata, e.wdata);
                  chk(t, "wb_valid", 32'(wb_valid), 32'(e.wbv));
                  if (e.wbv) chk(t, "wb_base", wb_base, e.wbd);
                  chk(t, "ld_valid", 32'(ld_valid), 32'(e.ldv));
                  if (e.ldv) chk(t, "ld_data", ld_data, e.ldd);
               end
            end
         end else if (wb_valid || ld_valid) begin
            chk("R9", "result without transfer", 32'd1, 32'd0);
         end
      end
   end

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R11: outputs quiet during reset
      chk("R11", "mem_valid in reset", 32'(mem_valid), 32'd0);
      chk("R11", "wb_valid in reset", 32'(wb_valid), 32'd0);
      chk("R11", "ld_valid in reset", 32'(ld_valid), 32'd0);
      chk("R11", "align_fault in reset", 32'(align_fault), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // mode codes: 0 indirect, 1 pre, 2 pre+wb, 3 post, 4 pc-relative
      issue("R1 store indirect", 3'd0, 1, 1, 0, 0, 32'h100, 0, 12'h000, 32'h12345678);
      issue("R1 load indirect",  3'd0, 1, 0, 0, 0, 32'h100, 0, 12'h000, 0);
      issue("R2 store pre",      3'd1, 1, 1, 0, 0, 32'h100, 0, 12'h004, 32'hA123B246);
      issue("R3 load pre wb",    3'd2, 1, 0, 0, 0, 32'h100, 0, 12'h004, 0);
      issue("R4 store post",     3'd3, 1, 1, 0, 0, 32'h108, 0, 12'h004, 32'h00000063);
      idle(2);
      // R9: pulses end once requests stop
      chk("R9", "mem_valid after idle", 32'(mem_valid), 32'd0);
      chk("R9", "wb_valid after idle", 32'(wb_valid), 32'd0);

      issue("R5 negative offset add",  3'd1, 1, 0, 0, 0, 32'h108, 0, 12'hFFC, 0);
      issue("R5 subtract offset",      3'd1, 0, 0, 0, 0, 32'h10C, 0, 12'h004, 0);
      issue("R5 subtract negative wb", 3'd2, 0, 0, 0, 0, 32'h100, 0, 12'hFF8, 0);
      issue("R6 pc-relative load",     3'd4, 1, 0, 0, 0, 32'h3F0, 32'h80, 12'h07C, 0);
      issue("R6 pc-relative store sub",3'd4, 0, 1, 0, 0, 32'h3F0, 32'h200, 12'h0FC, 32'h00000055);
      issue("R8 byte store lane 1",    3'd0, 1, 1, 1, 0, 32'h111, 0, 12'h000, 32'hCDCDCDAB);
      issue("R8 byte load lane 1",     3'd0, 1, 0, 1, 0, 32'h111, 0, 12'h000, 0);
      issue("R8 byte load lane 3 post",3'd3, 1, 0, 1, 0, 32'h103, 0, 12'h001, 0);
      issue("R7 misaligned load wb",   3'd2, 1, 0, 0, 0, 32'h102, 0, 12'h000, 0);
      issue("R7 misaligned store",     3'd3, 1, 1, 0, 0, 32'h101, 0, 12'h004, 32'hDEADBEEF);
      issue("R7 memory kept",          3'd0, 1, 0, 0, 0, 32'h100, 0, 12'h000, 0);
      issue("R10 load into base",      3'd2, 1, 0, 0, 1, 32'h100, 0, 12'h004, 0);
      issue("R10 store keeps wb",      3'd3, 1, 1, 0, 1, 32'h120, 0, 12'h008, 32'h0BADF00D);
      issue("R1 unused code 7",        3'd7, 1, 0, 0, 0, 32'h120, 0, 12'h008, 0);
      idle(3);
      chk("R9", "queue drained", 32'(q.size()), 32'd0);
      chk("R9", "ld_valid after idle", 32'(ld_valid), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule